// File: doc/BRIEF.md
# Multiplexed LCD Backplane and Segment Phase Generator

This block produces the per-line drive codes for a passive LCD panel with four common (backplane) lines and 32 segment lines. A frame is 24 input clocks long. Depending on the selected multiplex ratio, the frame is cut into one, two, three or four equal row slots. During each slot, one row's backplane is driven to a full-swing level, and every segment line is set to a level chosen from that row's bit in the display register. Every output is a 2-bit code that names one of four bias levels. An external analog stage turns these codes into voltages.

Consecutive frames use opposite polarity, so the panel never sees a net DC voltage. Display contents arrive on a shadow input and are copied into the working register only when a frame ends, so a frame never shows half-updated data. Several instances can be cascaded. One instance's sync output drives the sync input of the others, and each receiver restarts its frame timing on a rising edge so that all of them stay in phase.

Top module: `lcdmx_top`

## Requirements
- R1: A synchronous active-high reset clears the slot counter, the row phase, the polarity and the working display register. In the first cycle after reset the block shows row 0, polarity 0 and all segments off, and `sync_out` is high.
- R2: A frame lasts exactly 24 clocks, and polarity inverts at every frame boundary. `sync_out` is high for one cycle every 48 clocks, in the first cycle of each polarity-0 frame.
- R3: With N rows active (N = mode + 1; mode code 0 is static, 1 is 1:2, 2 is 1:3, 3 is 1:4), the frame is split into N slots of 24/N clocks each. Row k is selected in slot k.
- R4: Level codes are 0=VSS, 1=one third, 2=two thirds and 3=VDD. In the multiplex modes, a selected backplane is at 3 when polarity is 0 and at 0 when polarity is 1. An unselected backplane is at 1 when polarity is 0 and at 2 when polarity is 1.
- R5: In the multiplex modes, segment s uses bit `row*32+s` of the working register for the current row. An "on" segment is at 0 when polarity is 0 and at 3 when polarity is 1. An "off" segment is at 2 when polarity is 0 and at 1 when polarity is 1.
- R6: In static mode, all four backplanes carry one waveform: 0 when polarity is 0 and 3 when polarity is 1. A segment whose row-0 bit is 1 drives the opposite extreme, and a segment whose bit is 0 drives the backplane level.
- R7: In 1:3 mode, BP3 carries the same code as BP1 in every cycle.
- R8: In 1:2 mode, BP2 equals BP0 and BP3 equals BP1 in every cycle.
- R9: The shadow input is copied into the working register only on the last clock of a frame. A shadow change made mid-frame first appears in the cycle after that frame ends.
- R10: A rising edge of `sync_in` sampled at a clock edge puts the block at frame position 1 (row 0, second clock of the slot) with polarity 0 in the following cycle. A level held high does not trigger again, and a sync edge does not load the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock; 24 cycles per frame |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Multiplex ratio code: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| shadow_data | input | 128 | Next display contents, bit row*32+seg |
| sync_in | input | 1 | Cascade alignment input, rising-edge sensitive |
| sync_out | output | 1 | One-cycle pulse at the start of each polarity-0 frame |
| bp_lvl | output | 8 | Backplane level codes, BPk at bits [2k+1:2k] |
| seg_lvl | output | 64 | Segment level codes, segment s at bits [2s+1:2s] |

## Verification
The bench compares every output in every cycle against an arithmetic model of the frame position, in all four modes. This catches a design that sizes its slots wrongly, skips the polarity flip, or maps the mirrored backplanes to the wrong row: its codes would drift from the model within one slot. The shadow is changed in the middle of a frame. A design that loads it immediately would show the new pattern up to 18 cycles early. A sync pulse held high for three cycles is issued away from any boundary. A design that re-arms on the level, or that does not restart its count, would lose alignment with the model. Each mode is reached by a reset from a running state, which exposes any state that reset leaves uncleared.

// File: rtl/lcdmx_pkg.sv
package lcdmx_pkg;

    localparam int MAX_ROWS = 4;
    localparam int PHASE_W  = $clog2(MAX_ROWS);

    typedef enum logic [1:0] {
        LV_VSS      = 2'd0,
        LV_THIRD    = 2'd1,
        LV_TWOTHIRD = 2'd2,
        LV_VDD      = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        MX_1 = 2'd0,
        MX_2 = 2'd1,
        MX_3 = 2'd2,
        MX_4 = 2'd3
    } mux_e;

    typedef struct packed {
        logic               pol;
        logic [PHASE_W-1:0] phase;
    } tstate_t;

    function automatic int rows_of(input mux_e m);
        return int'(m) + 1;
    endfunction

    function automatic int slot_len(input mux_e m, input int div);
        case (m)
            MX_1:    return div;
            MX_2:    return div / 2;
            MX_3:    return div / 3;
            default: return div / 4;
        endcase
    endfunction

    // which row waveform a given backplane pin carries
    function automatic int bp_row(input mux_e m, input int k);
        case (m)
            MX_1:    return 0;
            MX_2:    return k % 2;
            MX_3:    return (k == 3) ? 1 : k;
            default: return k;
        endcase
    endfunction

    function automatic lvl_e bp_level(input mux_e m, input logic sel, input logic pol);
        if (m == MX_1) return pol ? LV_VDD : LV_VSS;
        if (sel)       return pol ? LV_VSS : LV_VDD;
        return pol ? LV_TWOTHIRD : LV_THIRD;
    endfunction

    function automatic lvl_e seg_level(input mux_e m, input logic on, input logic pol);
        if (m == MX_1) return (on ^ pol) ? LV_VDD : LV_VSS;
        if (on)        return pol ? LV_VDD : LV_VSS;
        return pol ? LV_THIRD : LV_TWOTHIRD;
    endfunction

endpackage

// File: rtl/lcdmx_frame_timer.sv
module lcdmx_frame_timer
    import lcdmx_pkg::*;
#(
    parameter int FRAME_DIV = 24
) (
    input  logic    clk,
    input  logic    rst,
    input  mux_e    mux,
    input  logic    sync_in,
    output tstate_t tm,
    output logic    load_en,
    output logic    sync_out
);
    localparam int CW = $clog2(FRAME_DIV);

    logic [CW-1:0] slot_cnt;
    logic          sync_q;
    logic          sync_rise;
    logic          last_slot;
    logic          last_phase;
    logic          frame_end;

    always_comb begin
        sync_rise  = sync_in & ~sync_q;
        last_slot  = int'(slot_cnt) >= slot_len(mux, FRAME_DIV) - 1;
        last_phase = int'(tm.phase) >= rows_of(mux) - 1;
        frame_end  = last_slot & last_phase;
        load_en    = frame_end & ~sync_rise;
        sync_out   = (slot_cnt == '0) && (tm.phase == '0) && !tm.pol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= '0;
            tm       <= '0;
            sync_q   <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (sync_rise) begin
                slot_cnt <= CW'(1);
                tm       <= '0;
            end else if (last_slot) begin
                slot_cnt <= '0;
                if (last_phase) begin
                    tm.phase <= '0;
                    tm.pol   <= ~tm.pol;
                end else begin
                    tm.phase <= tm.phase + 1'b1;
                end
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    // R2
    pol_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !sync_rise) |=> (tm.pol != $past(tm.pol)));

    // R2
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !sync_rise) |=> $stable(tm.pol));

    // R10
    sync_align_chk: assert property (@(posedge clk) disable iff (rst)
        sync_rise |=> (slot_cnt == CW'(1) && tm.phase == '0 && !tm.pol));

endmodule

// File: rtl/lcdmx_disp_latch.sv
module lcdmx_disp_latch
    import lcdmx_pkg::*;
#(
    parameter int NUM_SEG = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load_en,
    input  logic [MAX_ROWS-1:0][NUM_SEG-1:0]   shadow,
    output logic [MAX_ROWS-1:0][NUM_SEG-1:0]   act
);
    always_ff @(posedge clk) begin
        if (rst)          act <= '0;
        else if (load_en) act <= shadow;
    end

    // R9
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(act));

endmodule

// File: rtl/lcdmx_bp_drive.sv
module lcdmx_bp_drive
    import lcdmx_pkg::*;
#(
    parameter int NUM_BP = MAX_ROWS
) (
    input  logic              clk,
    input  logic              rst,
    input  mux_e              mux,
    input  tstate_t           tm,
    output lvl_e [NUM_BP-1:0] bp
);
    logic [NUM_BP-1:0] extreme;

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        logic sel;
        always_comb begin
            sel       = (PHASE_W'(bp_row(mux, k)) == tm.phase);
            bp[k]     = bp_level(mux, sel, tm.pol);
            extreme[k] = (bp[k] == LV_VSS) || (bp[k] == LV_VDD);
        end
    end

    // R7
    triplex_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mux == MX_3) |-> (bp[3] == bp[1]));

    // R8
    duplex_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mux == MX_2) |-> (bp[2] == bp[0] && bp[3] == bp[1]));

    // R4
    quad_one_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (mux == MX_4) |-> ($countones(extreme) == 1));

endmodule

// File: rtl/lcdmx_seg_drive.sv
module lcdmx_seg_drive
    import lcdmx_pkg::*;
#(
    parameter int NUM_SEG = 32
) (
    input  mux_e                             mux,
    input  tstate_t                          tm,
    input  logic [MAX_ROWS-1:0][NUM_SEG-1:0] act,
    output lvl_e [NUM_SEG-1:0]               seg
);
    logic [NUM_SEG-1:0] row_bits;

    always_comb row_bits = act[tm.phase];

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_comb seg[s] = seg_level(mux, row_bits[s], tm.pol);
    end

endmodule

// File: rtl/lcdmx_top.sv
module lcdmx_top
    import lcdmx_pkg::*;
#(
    parameter int NUM_SEG   = 32,
    parameter int FRAME_DIV = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [1:0]                      mode,
    input  logic [MAX_ROWS*NUM_SEG-1:0]     shadow_data,
    input  logic                            sync_in,
    output logic                            sync_out,
    output logic [2*MAX_ROWS-1:0]           bp_lvl,
    output logic [2*NUM_SEG-1:0]            seg_lvl
);
    mux_e                             mux;
    tstate_t                          tm;
    logic                             load_en;
    logic [MAX_ROWS-1:0][NUM_SEG-1:0] shadow_2d;
    logic [MAX_ROWS-1:0][NUM_SEG-1:0] act;
    lvl_e [MAX_ROWS-1:0]              bp;
    lvl_e [NUM_SEG-1:0]               seg;

    always_comb begin
        mux       = mux_e'(mode);
        shadow_2d = shadow_data;
        bp_lvl    = bp;
        seg_lvl   = seg;
    end

    lcdmx_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .mux      (mux),
        .sync_in  (sync_in),
        .tm       (tm),
        .load_en  (load_en),
        .sync_out (sync_out)
    );

    lcdmx_disp_latch #(.NUM_SEG(NUM_SEG)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .shadow  (shadow_2d),
        .act     (act)
    );

    lcdmx_bp_drive #(.NUM_BP(MAX_ROWS)) u_bp (
        .clk (clk),
        .rst (rst),
        .mux (mux),
        .tm  (tm),
        .bp  (bp)
    );

    lcdmx_seg_drive #(.NUM_SEG(NUM_SEG)) u_seg (
        .mux (mux),
        .tm  (tm),
        .act (act),
        .seg (seg)
    );

endmodule

// File: tb/sim_lcdmx_top.sv
`timescale 1ns/1ps
module sim_lcdmx_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'd0;
    logic [127:0] shadow = '0;
    logic         sync_in = 1'b0;
    logic         sync_out;
    logic [7:0]   bp_lvl;
    logic [63:0]  seg_lvl;

    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;
    int           q;
    logic [127:0] act_m;
    bit           sync_prev;
    logic [127:0] pat_a;
    logic [127:0] pat_b;

    lcdmx_top u0 (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .shadow_data (shadow),
        .sync_in     (sync_in),
        .sync_out    (sync_out),
        .bp_lvl      (bp_lvl),
        .seg_lvl     (seg_lvl)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    function automatic int cur_phase(input int m, input int qq);
        return (qq % 24) / (24 / (m + 1));
    endfunction

    function automatic logic [7:0] exp_bp(input int m, input int qq);
        logic [7:0] r;
        bit pol = (qq >= 24);
        int ph = cur_phase(m, qq);
        for (int k = 0; k < 4; k++) begin
            int row;
            int v;
            row = (m == 0) ? 0 : (m == 1) ? k % 2 : (m == 2) ? ((k == 3) ? 1 : k) : k;
            if (m == 0)        v = pol ? 3 : 0;
            else if (row == ph) v = pol ? 0 : 3;
            else               v = pol ? 2 : 1;
            r[2*k +: 2] = 2'(v);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_seg(input int m, input int qq, input logic [127:0] a);
        logic [63:0] r;
        bit pol = (qq >= 24);
        int ph = cur_phase(m, qq);
        for (int s = 0; s < 32; s++) begin
            bit d;
            int v;
            d = a[ph*32 + s];
            if (m == 0) v = (d ^ pol) ? 3 : 0;
            else if (d) v = pol ? 3 : 0;
            else        v = pol ? 1 : 2;
            r[2*s +: 2] = 2'(v);
        end
        return r;
    endfunction

    task automatic check_now(input int m, input string extra);
        string tb_tag;
        string ts_tag;
        logic [7:0]  eb;
        logic [63:0] es;
        case (m)
            0: tb_tag = "R6";
            1: tb_tag = "R8 R3";
            2: tb_tag = "R7 R3";
            default: tb_tag = "R4 R3";
        endcase
        ts_tag = (m == 0) ? "R6" : "R5";
        eb = exp_bp(m, q);
        es = exp_seg(m, q, act_m);
        chk(bp_lvl === eb, {tb_tag, extra, " bp"}, {56'd0, bp_lvl}, {56'd0, eb});
        chk(seg_lvl === es, {ts_tag, extra, " seg"}, seg_lvl, es);
        chk(sync_out === (q == 0), {"R2", extra, " sync_out"}, {63'd0, sync_out}, {63'd0, q == 0});
    endtask

    task automatic step();
        bit rise = sync_in && !sync_prev;
        if (rise) q = 1;
        else begin
            if (q % 24 == 23) act_m = shadow;
            q = (q + 1) % 48;
        end
        sync_prev = sync_in;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sync_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q = 0;
        act_m = '0;
        sync_prev = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            pat_a[i] = ((i * 5 + i / 7) % 3 == 0);
            pat_b[i] = ((i * 11) % 7 < 3);
        end
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            shadow = pat_a;
            do_reset();
            // R1: reset state, row 0, polarity 0, all off
            check_now(m, " R1");
            for (int cyc = 0; cyc < 120; cyc++) begin
                string extra;
                if (cyc == 30) shadow = pat_b;
                sync_in = (m == 3 && cyc >= 60 && cyc < 63);
                step();
                extra = "";
                if (cyc >= 30) extra = {extra, " R9"};
                if (m == 3 && cyc >= 60) extra = {extra, " R10"};
                check_now(m, extra);
            end
            sync_in = 1'b0;
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule